// File: doc/BRIEF.md
# Indexed Interrupt Controller with Polarity and Type Control

This block gathers up to `NUM_SRC` system interrupt lines and reduces them to one host interrupt request. Each line passes through its own conditioner. The conditioner is programmed as either level-sensitive or edge-sensitive, and its active sense is either high/rising or low/falling. The conditioner's result is held in a status bit.

A source is pending when its status bit and its enable bit are both set. Every source is assigned to a priority channel. An arbiter picks one winner among the pending sources and reports it through a prioritized-index register. That register carries a flag for the case where nothing is pending.

Software works through a word-addressed register port with a single-cycle write and a combinational read. Enables and status can be changed in two ways:

- by writing a source number to an index register;
- by write-one-to-clear bitmap words, each covering 32 sources.

The host request reaches the output only when the global enable and the enable for host 0 are both set.

Top module: `ixic_top`

## Requirements
- R1: After reset all enables are 0 and all status is 0. Every polarity bit is 1 and every type bit is 0 (level, active high). Every source sits on channel `NUM_CHAN-1`, so a channel-map word reads 0x07070707. The global enable and host enables read 0, `irq_o` is low, and the index register at 0x080 reads 0x8000_0000.
- R2: A level source (type bit 0) has status 1 one clock after its input is at the active level: high when its polarity bit is 1, low when it is 0. Status returns to 0 one clock after the input leaves that level. A status clear has no effect while the input is active.
- R3: An edge source (type bit 1) sets its status one clock after an active edge: rising when polarity is 1, falling when polarity is 0. Status stays set after the input returns, until it is cleared. Writing the source number to 0x024 clears it. When an active edge and a clear fall in the same cycle, the edge wins.
- R4: Writing a source number to 0x028 sets that source's enable, and writing it to 0x02C clears it. A number of `NUM_SRC` or more changes no enable.
- R5: Bitmap word n covers sources 32n+b at bit b. Word n is at 0x280+4n for status and at 0x380+4n for enables. A read returns the bits. A write clears every bit written as 1 and leaves the others unchanged.
- R6: `irq_o` is 1 exactly when bit 0 of the global enable register (0x010) is 1, host 0 is enabled, and at least one source is pending.
- R7: Writing a host number to 0x034 sets that host's enable, and writing it to 0x038 clears it. A number of `NUM_HOST` or more is ignored. The bitmap at 0x1500 reads and writes host h at bit h.
- R8: Register 0x080 returns the winning source in bits [9:0]. The lowest channel number wins. Among equal channels, the lowest source number wins.
- R9: When no source has both status and enable set, register 0x080 reads exactly 0x8000_0000. This holds even if some source has status without enable.
- R10: Channel-map word n at 0x400+4n holds sources 4n+k, each in byte k, with the channel in the byte's low `$clog2(NUM_CHAN)` bits. Higher bits of each byte read 0.
- R11: Polarity word n at 0xD00+4n and type word n at 0xD80+4n hold sources 32n+b at bit b. A type bit of 1 selects edge and 0 selects level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw system interrupt lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Host 0 interrupt request |

## Verification
The hardest situation to reach from the ports is an edge source whose status reflects only the intended edge. Reprogramming polarity or type while a line is already high can itself look like an active edge.

To avoid this, the stimulus table parks each line at its starting value before it rewrites polarity and type. It then waits two clocks and clears the status. Only after that does it apply a two-step input pattern, with an optional clear at the end.

Arbitration ties are reached by placing two pending sources on the same low channel, above a third source on a higher channel. The winner then has to come from the index rule and not from the channel rule.

// File: rtl/ixic_pkg.sv
package ixic_pkg;

  localparam logic [31:0] OFS_GLB_EN   = 32'h0000_0010;
  localparam logic [31:0] OFS_ST_CLR_I = 32'h0000_0024;
  localparam logic [31:0] OFS_EN_SET_I = 32'h0000_0028;
  localparam logic [31:0] OFS_EN_CLR_I = 32'h0000_002C;
  localparam logic [31:0] OFS_HS_SET_I = 32'h0000_0034;
  localparam logic [31:0] OFS_HS_CLR_I = 32'h0000_0038;
  localparam logic [31:0] OFS_WINNER   = 32'h0000_0080;
  localparam logic [31:0] OFS_ST_BMAP  = 32'h0000_0280;
  localparam logic [31:0] OFS_EN_BMAP  = 32'h0000_0380;
  localparam logic [31:0] OFS_CH_MAP   = 32'h0000_0400;
  localparam logic [31:0] OFS_POL      = 32'h0000_0D00;
  localparam logic [31:0] OFS_TYP      = 32'h0000_0D80;
  localparam logic [31:0] OFS_HS_BMAP  = 32'h0000_1500;

  // Address falls on a word inside a window of `count` words at `base`.
  function automatic logic win_hit(input logic [31:0] addr, input logic [31:0] base,
                                   input int count);
    return (addr >= base) && (addr < base + 32'(4 * count)) && (addr[1:0] == 2'b00);
  endfunction

  // Word number of an address inside a window.
  function automatic int win_word(input logic [31:0] addr, input logic [31:0] base);
    return int'((addr - base) >> 2);
  endfunction

  // A candidate channel overtakes the current best only when strictly lower.
  function automatic logic chan_ahead(input logic [7:0] cand, input logic [7:0] best);
    return cand < best;
  endfunction

endpackage

// File: rtl/ixic_src_cond.sv
module ixic_src_cond #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status,
  output logic [N-1:0] edge_evt,
  output logic [N-1:0] lvl_act
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise, fall;
    assign rise        = src_in[i] & ~prev_q[i];
    assign fall        = ~src_in[i] & prev_q[i];
    assign edge_evt[i] = typ[i] & (pol[i] ? rise : fall);
    assign lvl_act[i]  = ~typ[i] & ~(src_in[i] ^ pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        status[i] <= 1'b0;
      end else begin
        prev_q[i] <= src_in[i];
        if (typ[i])
          status[i] <= edge_evt[i] | (status[i] & ~clr[i]);
        else
          status[i] <= lvl_act[i];
      end
    end
  end

endmodule

// File: rtl/ixic_arbiter.sv
module ixic_arbiter
  import ixic_pkg::*;
#(
  parameter int N     = 128,
  parameter int CW    = 3,
  parameter int SRC_W = 7
) (
  input  logic [N-1:0]         pend,
  input  logic [N-1:0][CW-1:0] chan,
  output logic                 found,
  output logic [SRC_W-1:0]     idx
);

  always_comb begin
    logic          f;
    logic [CW-1:0] best;
    logic [SRC_W-1:0] win;
    f    = 1'b0;
    best = '1;
    win  = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (!f || chan_ahead(8'(chan[i]), 8'(best)))) begin
        f    = 1'b1;
        best = chan[i];
        win  = SRC_W'(i);
      end
    end
    found = f;
    idx   = win;
  end

endmodule

// File: rtl/ixic_top.sv
module ixic_top
  import ixic_pkg::*;
#(
  parameter int NUM_SRC  = 128,
  parameter int NUM_CHAN = 8,
  parameter int NUM_HOST = 2,
  parameter int ADDR_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CW    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
  localparam int NSW   = (NUM_SRC + 31) / 32;
  localparam int NCW   = (NUM_SRC + 3) / 4;
  localparam logic [CW-1:0] CH_RST = CW'(NUM_CHAN - 1);

  logic [31:0]               addr32;
  logic [NUM_SRC-1:0]        pol_q, typ_q, en_q;
  logic [NUM_SRC-1:0]        status, edge_evt, lvl_act, clr, pend;
  logic [NUM_SRC-1:0]        en_set, en_clr;
  logic [NUM_SRC-1:0][CW-1:0] chan_q;
  logic [NUM_HOST-1:0]       hen_q;
  logic                      glb_en;
  logic                      pi_found;
  logic [SRC_W-1:0]          pi_idx;

  // decoded write events
  logic wr_glb, wr_stclr_i, wr_enset_i, wr_enclr_i, wr_hset_i, wr_hclr_i;
  logic wr_st_bm, wr_en_bm, wr_cmap, wr_pol, wr_typ, wr_hen_bm;
  logic idx_ok, host_ok;
  logic [SRC_W-1:0] widx;
  int st_word, en_word, cm_word, pol_word, typ_word;

  assign addr32  = 32'(bus_addr);
  assign idx_ok  = bus_wdata < 32'(NUM_SRC);
  assign host_ok = bus_wdata < 32'(NUM_HOST);
  assign widx    = bus_wdata[SRC_W-1:0];

  assign wr_glb     = bus_wr && (addr32 == OFS_GLB_EN);
  assign wr_stclr_i = bus_wr && (addr32 == OFS_ST_CLR_I) && idx_ok;
  assign wr_enset_i = bus_wr && (addr32 == OFS_EN_SET_I) && idx_ok;
  assign wr_enclr_i = bus_wr && (addr32 == OFS_EN_CLR_I) && idx_ok;
  assign wr_hset_i  = bus_wr && (addr32 == OFS_HS_SET_I) && host_ok;
  assign wr_hclr_i  = bus_wr && (addr32 == OFS_HS_CLR_I) && host_ok;
  assign wr_st_bm   = bus_wr && win_hit(addr32, OFS_ST_BMAP, NSW);
  assign wr_en_bm   = bus_wr && win_hit(addr32, OFS_EN_BMAP, NSW);
  assign wr_cmap    = bus_wr && win_hit(addr32, OFS_CH_MAP, NCW);
  assign wr_pol     = bus_wr && win_hit(addr32, OFS_POL, NSW);
  assign wr_typ     = bus_wr && win_hit(addr32, OFS_TYP, NSW);
  assign wr_hen_bm  = bus_wr && (addr32 == OFS_HS_BMAP);

  assign st_word  = win_word(addr32, OFS_ST_BMAP);
  assign en_word  = win_word(addr32, OFS_EN_BMAP);
  assign cm_word  = win_word(addr32, OFS_CH_MAP);
  assign pol_word = win_word(addr32, OFS_POL);
  assign typ_word = win_word(addr32, OFS_TYP);

  // per-source clear / enable strobes from both access styles
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      clr[i]    = (wr_stclr_i && widx == SRC_W'(i)) ||
                  (wr_st_bm && st_word == i / 32 && bus_wdata[i % 32]);
      en_set[i] = wr_enset_i && widx == SRC_W'(i);
      en_clr[i] = (wr_enclr_i && widx == SRC_W'(i)) ||
                  (wr_en_bm && en_word == i / 32 && bus_wdata[i % 32]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      glb_en <= 1'b0;
      hen_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) chan_q[i] <= CH_RST;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      if (wr_glb) glb_en <= bus_wdata[0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wr_pol && pol_word == i / 32) pol_q[i] <= bus_wdata[i % 32];
        if (wr_typ && typ_word == i / 32) typ_q[i] <= bus_wdata[i % 32];
        if (wr_cmap && cm_word == i / 4) chan_q[i] <= bus_wdata[8 * (i % 4) +: CW];
      end
      for (int h = 0; h < NUM_HOST; h++) begin
        if (wr_hen_bm)                            hen_q[h] <= bus_wdata[h];
        else if (wr_hset_i && bus_wdata == 32'(h)) hen_q[h] <= 1'b1;
        else if (wr_hclr_i && bus_wdata == 32'(h)) hen_q[h] <= 1'b0;
      end
    end
  end

  ixic_src_cond #(.N(NUM_SRC)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .pol      (pol_q),
    .typ      (typ_q),
    .clr      (clr),
    .status   (status),
    .edge_evt (edge_evt),
    .lvl_act  (lvl_act)
  );

  assign pend = status & en_q;

  ixic_arbiter #(.N(NUM_SRC), .CW(CW), .SRC_W(SRC_W)) u_arb (
    .pend  (pend),
    .chan  (chan_q),
    .found (pi_found),
    .idx   (pi_idx)
  );

  assign irq_o = glb_en & hen_q[0] & (|pend);

  // combinational read port
  always_comb begin
    bus_rdata = '0;
    if (addr32 == OFS_GLB_EN) begin
      bus_rdata[0] = glb_en;
    end else if (addr32 == OFS_WINNER) begin
      bus_rdata[31]  = ~pi_found;
      bus_rdata[9:0] = pi_found ? 10'(pi_idx) : 10'd0;
    end else if (addr32 == OFS_HS_BMAP) begin
      bus_rdata[NUM_HOST-1:0] = hen_q;
    end else if (win_hit(addr32, OFS_ST_BMAP, NSW)) begin
      for (int b = 0; b < 32; b++)
        if (32 * st_word + b < NUM_SRC) bus_rdata[b] = status[32 * st_word + b];
    end else if (win_hit(addr32, OFS_EN_BMAP, NSW)) begin
      for (int b = 0; b < 32; b++)
        if (32 * en_word + b < NUM_SRC) bus_rdata[b] = en_q[32 * en_word + b];
    end else if (win_hit(addr32, OFS_POL, NSW)) begin
      for (int b = 0; b < 32; b++)
        if (32 * pol_word + b < NUM_SRC) bus_rdata[b] = pol_q[32 * pol_word + b];
    end else if (win_hit(addr32, OFS_TYP, NSW)) begin
      for (int b = 0; b < 32; b++)
        if (32 * typ_word + b < NUM_SRC) bus_rdata[b] = typ_q[32 * typ_word + b];
    end else if (win_hit(addr32, OFS_CH_MAP, NCW)) begin
      for (int k = 0; k < 4; k++)
        if (4 * cm_word + k < NUM_SRC) bus_rdata[8 * k +: CW] = chan_q[4 * cm_word + k];
    end
  end

endmodule

// File: rtl/ixic_chk.sv
module ixic_chk #(
  parameter int NUM_SRC = 128,
  parameter int SRC_W   = 7,
  parameter int ADDR_W  = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               glb_en,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] edge_evt,
  input logic [NUM_SRC-1:0] lvl_act,
  input logic [NUM_SRC-1:0] clr,
  input logic [NUM_SRC-1:0] typ,
  input logic [NUM_SRC-1:0] en,
  input logic               pi_found,
  input logic [SRC_W-1:0]   pi_idx,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata
);

  // R2 / R3: an active level or active edge shows up in status next cycle
  assert_cond_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_evt | lvl_act)) |=>
      ((status & $past(edge_evt | lvl_act)) == $past(edge_evt | lvl_act)));

  // R3: a clear on an edge source without a new edge empties its status
  assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & typ & ~edge_evt)) |=> ((status & $past(clr & typ & ~edge_evt)) == '0));

  // R4: an in-range index written to the set register enables that source
  assert_idx_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 32'(bus_addr) == 32'h28 && bus_wdata < 32'(NUM_SRC)) |=>
      en[$past(bus_wdata[SRC_W-1:0])]);

  // R6: the host request implies an arbitration winner and the global gate
  assert_irq_needs_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pi_found && glb_en));

  // R8: the reported winner is itself pending
  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pi_found |-> pend[pi_idx]);

  // R9: the none flag matches the absence of pending sources
  assert_none_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !pi_found);

  assert_found_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> pi_found);

endmodule

bind ixic_top ixic_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .glb_en    (glb_en),
  .pend      (pend),
  .status    (status),
  .edge_evt  (edge_evt),
  .lvl_act   (lvl_act),
  .clr       (clr),
  .typ       (typ_q),
  .en        (en_q),
  .pi_found  (pi_found),
  .pi_idx    (pi_idx),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/ixic_top_bench.sv
module ixic_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;

  // fields: [6] type, [5] polarity, [4] in0, [3] in1, [2] in2, [1] clear, [0] expected status
  localparam logic [6:0] VEC [14] = '{
    7'b0101101, 7'b0101000, 7'b0111111, 7'b0010001, 7'b0000100, 7'b0000011,
    7'b1101001, 7'b1101010, 7'b1110000, 7'b1111100, 7'b1100101,
    7'b1010101, 7'b1000100, 7'b1010010
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic            bus_wr = 1'b0;
  logic [12:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ixic_top u_ixic_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(13'h080, d); chk("R1 winner none", d, 32'h8000_0000);
    rd(13'h400, d); chk("R1 chan map", d, 32'h0707_0707);
    rd(13'h380, d); chk("R1 enables", d, 32'd0);
    rd(13'h1500, d); chk("R1 host enables", d, 32'd0);
    rd(13'hD00, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(13'hD80, d); chk("R1 type", d, 32'd0);

    // R2 / R3 / R11 conditioning table on source 5
    for (int v = 0; v < 14; v++) begin
      logic [6:0] e;
      e = VEC[v];
      src_in[5] = e[4];
      wr(13'hD00, e[5] ? 32'hFFFF_FFFF : 32'hFFFF_FFDF);
      wr(13'hD80, e[6] ? 32'h0000_0020 : 32'h0);
      tick(2);
      wr(13'h024, 32'd5);
      @(negedge clk); src_in[5] = e[3];
      @(negedge clk); src_in[5] = e[2];
      if (e[1]) wr(13'h024, 32'd5); else tick(1);
      rd(13'h280, d);
      chk(e[6] ? $sformatf("R3 edge vec %0d", v) : $sformatf("R2 level vec %0d", v),
          {31'd0, d[5]}, {31'd0, e[0]});
    end
    src_in[5] = 1'b0;
    wr(13'hD00, 32'hFFFF_FFFF);
    wr(13'hD80, 32'h0);
    wr(13'h024, 32'd5);

    // R10 channel map layout and masking
    wr(13'h404, 32'h0000_0302);
    rd(13'h404, d); chk("R10 byte per source", d, 32'h0000_0302);
    wr(13'h408, 32'hFFFF_FFFF);
    rd(13'h408, d); chk("R10 upper bits read zero", d, 32'h0707_0707);

    // R8 arbitration: 5 on ch3, 9 and 100 on ch7
    src_in[5] = 1'b1; src_in[9] = 1'b1; src_in[100] = 1'b1;
    wr(13'h028, 32'd5); wr(13'h028, 32'd9); wr(13'h028, 32'd100);
    rd(13'h080, d); chk("R8 lowest channel", d, 32'd5);
    wr(13'h464, 32'h0707_0701);
    rd(13'h080, d); chk("R8 channel 1 beats 3", d, 32'd100);
    wr(13'h408, 32'h0707_0107);
    rd(13'h080, d); chk("R8 tie lowest index", d, 32'd9);
    wr(13'h02C, 32'd9); wr(13'h02C, 32'd100);
    rd(13'h080, d); chk("R8 after disables", d, 32'd5);

    // R9 status without enable is not pending
    wr(13'h02C, 32'd5);
    rd(13'h080, d); chk("R9 none flag", d, 32'h8000_0000);
    rd(13'h280, d); chk("R9 status still set", {31'd0, d[5]}, 32'd1);

    // R4 out-of-range index ignored, in-range set/clear
    wr(13'h028, 32'd200);
    for (int w = 0; w < 4; w++) begin
      rd(13'(13'h380 + 4 * w), d); chk($sformatf("R4 ignored index word %0d", w), d, 32'd0);
    end
    wr(13'h028, 32'd64);
    rd(13'h388, d); chk("R4 index set", d, 32'd1);
    wr(13'h02C, 32'd64);
    rd(13'h388, d); chk("R4 index clear", d, 32'd0);

    // R6 / R7 output gating
    wr(13'h028, 32'd5);
    chk("R6 no enables", {31'd0, irq_o}, 32'd0);
    wr(13'h034, 32'd0);
    chk("R6 host only", {31'd0, irq_o}, 32'd0);
    wr(13'h010, 32'd1);
    chk("R6 all gates open", {31'd0, irq_o}, 32'd1);
    wr(13'h010, 32'd2);
    chk("R6 global bit0 zero", {31'd0, irq_o}, 32'd0);
    wr(13'h010, 32'd1);
    wr(13'h038, 32'd0);
    chk("R7 host index clear", {31'd0, irq_o}, 32'd0);
    wr(13'h1500, 32'd1);
    chk("R7 host bitmap set", {31'd0, irq_o}, 32'd1);
    wr(13'h034, 32'd1);
    rd(13'h1500, d); chk("R7 host 1 set", d, 32'd3);
    wr(13'h034, 32'd5);
    rd(13'h1500, d); chk("R7 host out of range", d, 32'd3);
    wr(13'h02C, 32'd5);
    chk("R6 no pending", {31'd0, irq_o}, 32'd0);

    // R5 bitmap status and enable on source 40 (word 1 bit 8)
    wr(13'hD84, 32'h0000_0100);
    tick(2);
    wr(13'h284, 32'h0000_0100);
    src_in[40] = 1'b1;
    tick(1);
    src_in[40] = 1'b0;
    tick(1);
    rd(13'h284, d); chk("R5 edge status word 1", d, 32'h0000_0100);
    wr(13'h284, 32'h0000_0100);
    rd(13'h284, d); chk("R5 status w1c", d, 32'd0);
    wr(13'h028, 32'd40); wr(13'h028, 32'd41);
    rd(13'h384, d); chk("R5 enable bitmap", d, 32'h0000_0300);
    wr(13'h384, 32'h0000_0100);
    rd(13'h384, d); chk("R5 enable w1c", d, 32'h0000_0200);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule